// File: doc/BRIEF.md
# Double-Buffered PWM Compare Timer

A single-output pulse-width modulator built around a free-running counter, a period register and one duty compare register. The counter either counts up from zero to the period and wraps, or counts up to the period and back down to zero. In up counting the output follows a reset/set rule: it is set at the period boundary and cleared when the count meets the compare value. In up/down counting the output toggles on each compare match, is forced low at the peak and is realigned at the valley. The result is a pulse centred on count zero.

Software reaches the block through a write-strobe bus with three registers: control, period and compare. A control bit picks how period and compare writes take effect. In immediate mode a write reaches the comparator at once. This can make the output miss a compare match for a whole period when the new value lands at or below the running count. In buffered mode writes go to a holding copy, which is moved into the working registers only at the period boundary. A rewrite in mid-period therefore cannot disturb the cycle in progress.

A one-clock boundary tick marks the end of every period. Control bits also start and stop the counter and give a synchronous clear.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset the output, the boundary tick and the count are all 0, and the counter is stopped.
- R2: In up counting (control bit 1 = 0) the count runs 0,1,...,P and then wraps to 0, where P is the period register (address 1). Each cycle lasts P+1 clocks, and the boundary tick is high exactly while the count equals P.
- R3: In up counting with compare C (address 2), every full period after the first boundary following enable drives the output high for counts below C and low from C up to P.
- R4: In immediate mode (control bit 2 = 0), a compare write is used from the second count after the write strobe onward.
- R5: In immediate mode, when the running compare is above the count and the written value is at or below the count that follows the write, no match occurs. The output then stays high for the rest of that period and through the boundary.
- R6: In buffered mode (control bit 2 = 1), period and compare writes leave the current period unchanged and take effect from the count after the next boundary tick.
- R7: In up counting, a compare of 0 gives a constant low output and a compare greater than P gives a constant high output.
- R8: In up/down counting (control bit 1 = 1) the count climbs from 0 to P and descends back to 0, changing by exactly one each clock. A cycle lasts 2P clocks, and the boundary tick is high while the count is 0 on the way down.
- R9: In up/down counting with 0 < C < P, the output is high for counts below C while climbing and for counts at or below C while descending, and low elsewhere.
- R10: In up/down counting with buffered mode, held values are loaded at the valley boundary, so the new compare applies from count 1 of the next climb.
- R11: With the enable bit (control bit 0) low, the count and the output hold their values and no boundary tick occurs.
- R12: Writing control with bit 3 set clears the count to 0, sets the direction to up and drives the output low on the next clock edge. The bit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 period, 2 compare, 3 unused |
| wrData | input | CNT_W | Write data; for control, bit0 enable, bit1 up/down, bit2 buffered, bit3 clear |
| pwmOut | output | 1 | PWM output |
| periodTick | output | 1 | High for one clock in the last count of each period |
| countOut | output | CNT_W | Present counter value |

## Verification
The bench builds the block with its default 16-bit counter. It uses short periods of 5, 6 and 9 counts so that every count of a period can be checked across many periods and in both counting modes. A compare above the period and a compare of zero cover the saturated outputs. One long run with a period of 0xFFF and a compare of 0x7FF checks half duty over a wide count range. Mid-period rewrites placed on exact counts show the missed match in immediate mode and its absence in buffered mode. Period-length changes confirm that the boundary tick moves in step with the buffered load.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd2;

  // control register bit positions
  localparam int BIT_EN  = 0;
  localparam int BIT_UD  = 1;
  localparam int BIT_SH  = 2;
  localparam int BIT_CLR = 3;

  typedef struct packed {
    logic run;
    logic upDown;
    logic clr;
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_dbuf_ctrl.sv
module pwm_dbuf_ctrl
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [CNT_W-1:0]     wrData,
  input  logic                 periodEnd,
  output pwm_strobe_t          strobe,
  output logic [CNT_W-1:0]     activePer,
  output logic [CNT_W-1:0]     activeCmp,
  output logic [CNT_W-1:0]     cmpNext
);
  logic enReg, udReg, shReg;
  logic [CNT_W-1:0] holdPer, holdCmp;
  logic wrCtrl, wrPer, wrCmp;

  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
  assign wrPer  = wrEn && (wrAddr == ADDR_PER);
  assign wrCmp  = wrEn && (wrAddr == ADDR_CMP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      udReg     <= 1'b0;
      shReg     <= 1'b0;
      holdPer   <= '0;
      holdCmp   <= '0;
      activePer <= '0;
      activeCmp <= '0;
    end else begin
      if (wrCtrl) begin
        enReg <= wrData[BIT_EN];
        udReg <= wrData[BIT_UD];
        shReg <= wrData[BIT_SH];
      end
      if (wrPer) holdPer <= wrData;
      if (wrCmp) holdCmp <= wrData;
      if (shReg) begin
        if (periodEnd) begin
          activePer <= holdPer;
          activeCmp <= holdCmp;
        end
      end else begin
        if (wrPer) activePer <= wrData;
        if (wrCmp) activeCmp <= wrData;
      end
    end
  end

  // compare value that will be in force after the coming boundary
  assign cmpNext = shReg ? holdCmp : activeCmp;

  always_comb begin
    strobe.run    = enReg;
    strobe.upDown = udReg;
    strobe.clr    = wrCtrl && wrData[BIT_CLR];
  end

  // R6: buffered mode leaves working registers untouched between boundaries
  a_r6_hold_between_boundaries: assert property (@(posedge clk) disable iff (!rstN)
    (shReg && !periodEnd) |=> ($stable(activePer) && $stable(activeCmp)));

  // R4: immediate mode puts the written compare into service on the next edge
  a_r4_immediate_load: assert property (@(posedge clk) disable iff (!rstN)
    (!shReg && wrEn && wrAddr == ADDR_CMP) |=> (activeCmp == $past(wrData)));
endmodule

// File: rtl/pwm_dbuf_datapath.sv
module pwm_dbuf_datapath
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pwm_strobe_t          strobe,
  input  logic [CNT_W-1:0]     activePer,
  input  logic [CNT_W-1:0]     activeCmp,
  input  logic [CNT_W-1:0]     cmpNext,
  output logic [CNT_W-1:0]     count,
  output logic                 pwmOut,
  output logic                 periodEnd
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, nextCnt;
  logic dirDown, nextDown;
  logic pwmQ, nextPwm;
  logic cmpHit;

  always_comb begin
    if (!strobe.run || strobe.clr)  periodEnd = 1'b0;
    else if (!strobe.upDown)        periodEnd = (cnt >= activePer);
    else if (activePer == '0)       periodEnd = 1'b1;
    else                            periodEnd = dirDown && (cnt == '0);
  end

  always_comb begin
    nextCnt  = cnt;
    nextDown = dirDown;
    if (strobe.run) begin
      if (!strobe.upDown) begin
        nextDown = 1'b0;
        nextCnt  = (cnt >= activePer) ? '0 : cnt + ONE;
      end else if (activePer == '0) begin
        nextDown = 1'b0;
        nextCnt  = '0;
      end else if (!dirDown) begin
        if (cnt >= activePer) begin
          nextDown = 1'b1;
          nextCnt  = cnt - ONE;
        end else begin
          nextCnt  = cnt + ONE;
        end
      end else if (cnt == '0) begin
        nextDown = 1'b0;
        nextCnt  = ONE;
      end else begin
        nextCnt  = cnt - ONE;
      end
    end
  end

  assign cmpHit = (activeCmp != '0) && (nextCnt == activeCmp);

  always_comb begin
    nextPwm = pwmQ;
    if (strobe.run) begin
      if (!strobe.upDown) begin
        if (periodEnd)   nextPwm = (cmpNext != '0);
        else if (cmpHit) nextPwm = 1'b0;
      end else begin
        if (periodEnd)                       nextPwm = (cmpNext > ONE);
        else if (nextCnt == activePer)       nextPwm = 1'b0;
        else if (cmpHit)                     nextPwm = ~pwmQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dirDown <= 1'b0;
      pwmQ    <= 1'b0;
    end else if (strobe.clr) begin
      cnt     <= '0;
      dirDown <= 1'b0;
      pwmQ    <= 1'b0;
    end else begin
      cnt     <= nextCnt;
      dirDown <= nextDown;
      pwmQ    <= nextPwm;
    end
  end

  assign count  = cnt;
  assign pwmOut = pwmQ;

  // R2: up counting returns to zero after reaching the period
  a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.clr && !strobe.upDown && cnt >= activePer) |=> (cnt == '0));

  // R8: up/down counting moves by exactly one per clock
  a_r8_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.clr && strobe.upDown && activePer != '0)
      |=> (cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE));

  // R11: stopped counter holds count and output
  a_r11_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.clr) |=> ($stable(cnt) && $stable(pwmQ)));

  // R12: clear strobe empties the counter and lowers the output
  a_r12_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (cnt == '0 && !pwmQ && !dirDown));

  // R7: a zero compare keeps the up-counting output low
  a_r7_zero_low: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.upDown && activeCmp == '0 && cmpNext == '0 && !pwmQ) |=> !pwmQ);
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmOut,
  output logic              periodTick,
  output logic [CNT_W-1:0]  countOut
);
  pwm_strobe_t      strobe;
  logic [CNT_W-1:0] activePer, activeCmp, cmpNext;
  logic             periodEnd;

  pwm_dbuf_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .periodEnd (periodEnd),
    .strobe    (strobe),
    .activePer (activePer),
    .activeCmp (activeCmp),
    .cmpNext   (cmpNext)
  );

  pwm_dbuf_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .activePer (activePer),
    .activeCmp (activeCmp),
    .cmpNext   (cmpNext),
    .count     (countOut),
    .pwmOut    (pwmOut),
    .periodEnd (periodEnd)
  );

  assign periodTick = periodEnd;
endmodule

// File: tb/pwm_dbuf_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_dbuf_timer_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic pwmOut, periodTick;
  logic [CNT_W-1:0] countOut;

  always #4 clk = ~clk;  // 125 MHz

  pwm_dbuf_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .periodTick(periodTick), .countOut(countOut)
  );

  typedef struct {
    logic             pwm;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    string            req;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: compare one expected item per clock, 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(pwmOut == e.pwm && periodTick == e.tick && countOut == e.cnt, e.req,
            "{pwm,tick,count}", {pwmOut, periodTick, countOut}, {e.pwm, e.tick, e.cnt});
    end
  end

  task automatic pushItem(logic p, logic t, int c, string req);
    exp_t e;
    e.pwm = p; e.tick = t; e.cnt = CNT_W'(c); e.req = req;
    expQ.push_back(e);
  endtask

  // up counting: high below C, tick at P
  task automatic pushUp(int per, int cmp, string req);
    for (int k = 0; k <= per; k++) pushItem(k < cmp, k == per, k, req);
  endtask

  // up/down counting: climb 1..P then descend P-1..0
  task automatic pushUd(int per, int cmp, string req);
    for (int k = 1; k <= per; k++) pushItem(k < cmp, 1'b0, k, req);
    for (int k = per - 1; k >= 0; k--) pushItem(k <= cmp, k == 0, k, req);
  endtask

  task automatic busWrite(logic [1:0] a, int d);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic syncTick(string req);
    bit seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (periodTick) seen = 1;
    end
    if (!seen) check(1'b0, req, "boundary tick seen", 0, 1);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", "run completed", 0, 1);
    finishRun();
  end

  initial begin
    logic [CNT_W-1:0] heldCnt;
    logic heldPwm;
    waitCycles(3);
    // R1: reset state
    check(pwmOut == 1'b0, "R1", "pwmOut", pwmOut, 0);
    check(periodTick == 1'b0, "R1", "periodTick", periodTick, 0);
    check(countOut == '0, "R1", "countOut", countOut, 0);
    rstN = 1'b1;
    waitCycles(2);
    check(countOut == '0, "R1", "count stopped", countOut, 0);

    // R2 / R3: up counting, immediate mode
    busWrite(2'd1, 9);
    busWrite(2'd2, 6);
    busWrite(2'd0, 1);
    syncTick("R2");
    pushUp(9, 6, "R3");
    pushUp(9, 6, "R2");
    drain();
    busWrite(2'd1, 'hFFF);
    busWrite(2'd2, 'h7FF);
    syncTick("R3");
    pushUp('hFFF, 'h7FF, "R3");
    drain();
    busWrite(2'd1, 9);

    // R7: saturated compare values
    busWrite(2'd2, 0);
    syncTick("R7");
    pushUp(9, 0, "R7");
    drain();
    busWrite(2'd2, 12);
    syncTick("R7");
    pushUp(9, 12, "R7");
    drain();

    // R4: immediate write above the count takes effect in the same period
    busWrite(2'd2, 6);
    syncTick("R4");
    pushUp(9, 8, "R4");
    pushUp(9, 8, "R4");
    waitCycles(3);         // now at count 2
    busWrite(2'd2, 8);
    drain();

    // R5: immediate write below the count misses the match
    syncTick("R5");
    pushUp(9, 10, "R5");   // whole period high
    pushUp(9, 3, "R5");
    waitCycles(6);         // now at count 5
    busWrite(2'd2, 3);
    drain();

    // R6: buffered writes wait for the boundary
    busWrite(2'd2, 8);
    busWrite(2'd0, 1 | 4);
    syncTick("R6");
    pushUp(9, 8, "R6");
    pushUp(5, 3, "R6");
    pushUp(5, 3, "R6");
    waitCycles(5);         // now at count 4
    busWrite(2'd1, 5);
    busWrite(2'd2, 3);
    drain();

    // R11: stop holds count and output
    busWrite(2'd0, 4);
    heldCnt = countOut;
    heldPwm = pwmOut;
    check(countOut == '0, "R11", "count held at start", countOut, 0);
    check(pwmOut == 1'b1, "R11", "pwm held high", pwmOut, 1);
    waitCycles(6);
    check(countOut == heldCnt, "R11", "count stable", countOut, heldCnt);
    check(pwmOut == heldPwm, "R11", "pwm stable", pwmOut, heldPwm);
    check(periodTick == 1'b0, "R11", "no tick when stopped", periodTick, 0);

    // R12: clear while running
    busWrite(2'd0, 1);
    waitCycles(3);
    check(countOut != '0, "R12", "count running before clear", countOut, 1);
    busWrite(2'd0, 8);
    check(countOut == '0, "R12", "count cleared", countOut, 0);
    check(pwmOut == 1'b0, "R12", "pwm cleared", pwmOut, 0);
    waitCycles(2);
    check(countOut == '0, "R12", "clear bit not stored, stopped", countOut, 0);

    // R8 / R9: up/down counting, immediate mode
    busWrite(2'd1, 6);
    busWrite(2'd2, 3);
    busWrite(2'd0, 1 | 2);
    syncTick("R8");
    pushUd(6, 3, "R8");
    pushUd(6, 3, "R9");
    drain();

    // R10: buffered load at the valley
    busWrite(2'd0, 1 | 2 | 4);
    syncTick("R10");
    pushUd(6, 3, "R10");
    pushUd(6, 2, "R10");
    waitCycles(3);         // climbing, count 3
    busWrite(2'd2, 2);
    drain();

    waitCycles(2);
    finishRun();
  end
endmodule